// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is a target (responder) on a two-wire open-drain serial bus. Each line is seen through an input that reads the wired-AND level and driven through a pull-low enable; the block never drives a line high. It watches for start and stop conditions and answers to one 7-bit address and one 10-bit address, both set by parameters. Every byte it takes in is acknowledged. It fronts a bank of sixteen byte-wide registers.

Access goes through an internal register pointer. In a write, the first data byte after the address sets the pointer. Each byte written or read after that uses the pointer and then moves it on by one, wrapping at the top of the bank. A read returns the byte at the pointer, so a controller sets the pointer in a write and then reads after a repeated start. For 10-bit reads, the controller writes both address bytes first and then sends the read header after a repeated start.

After every acknowledge slot of a transfer addressed to it, the target holds SCL low for a fixed number of system clocks while it prepares the next byte. Both lines pass through a two-stage synchronizer before any decoding.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset both pull outputs are 0 and every register byte reads back 0x00.
- R2: A first byte whose upper seven bits equal ADDR7 is acknowledged by SDA low in the ninth clock. Any other first byte that is not a matching 10-bit header gets no acknowledge, and the bytes after it neither move the pointer nor change a register until the next start or stop.
- R3: The 10-bit header 11110, ADDR10[9:8], 0 (bits MSB first) is acknowledged. A following byte equal to ADDR10[7:0] is acknowledged and opens a write. A differing second byte is not acknowledged.
- R4: A 10-bit header with direction bit 1 is acknowledged only when a full 10-bit match has occurred since the last stop with no other first byte in between. The target then sends data.
- R5: In a write, the low four bits of the first data byte load the pointer. Each later data byte is stored at the pointer, and the pointer then advances by one. Every data byte is acknowledged.
- R6: In a read (direction bit 1, the last bit of the first byte), the target sends the byte at the pointer, MSB first, and advances the pointer after each byte. The pointer keeps its value between transfers.
- R7: The pointer advances from 15 to 0.
- R8: When the controller answers a sent byte with NAK (SDA high), the target releases SDA. Later clocks read all ones until a start or stop.
- R9: After each acknowledge slot of a selected transfer, the target holds SCL low for exactly STRETCH_CYCLES clock cycles. It starts holding only while SCL is low.
- R10: A repeated start, with no stop before it, restarts address matching.
- R11: A stop returns the target to idle with both pull outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or data 0) |

## Verification
Two actions share one cycle: the SCL falling edge that closes an acknowledge slot. In that cycle the target sets its SDA drive (releasing it, or putting out the first bit of a read byte) and starts the SCL hold. The bench provokes this on every byte with a controller model that honours stretching. It judges the result by the bit value seen at the next SCL high and by the measured length of every hold. The pointer update strobe and the byte load for a read also meet at the acknowledge boundary. Wrap-around reads and back-to-back reads without a new pointer show whether the next byte came from the advanced pointer.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the serial register target.
// Assumes bytes are eight bits wide, as the bus protocol fixes.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer seen
        ST_ADDR1,  // taking in first address byte
        ST_ADDR2,  // taking in low byte of a 10-bit address
        ST_ACK,    // pulling SDA for an acknowledge slot
        ST_WR,     // taking in a data byte
        ST_RD,     // sending a data byte
        ST_RACK,   // reading the controller acknowledge
        ST_WAIT    // not selected, ignore until start or stop
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and marks bus events.
// Assumes lines idle high; start and stop are SDA edges while SCL stays high.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff, sda_ff;
    logic          scl_q, sda_q;

    // synchronizer chains, reset to the released level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[LAST-1:0], scl_i};
            sda_ff <= {sda_ff[LAST-1:0], sda_i};
        end
    end

    assign scl_s = scl_ff[LAST];
    assign sda_s = sda_ff[LAST];

    // one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // event decode
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_reg_bank.sv
// Register bank with a wrapping pointer.
// Assumes at most one of load, write and step is active per cycle.
module i2c_reg_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [PW-1:0] ptr_val,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ptr_step,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_next;

    // pointer plus one with wrap at the last entry
    always_comb begin
        ptr_next = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end

    // pointer register: load, or advance after a byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr <= '0;
        else if (ptr_load)          ptr <= ptr_val;
        else if (wr_en || ptr_step) ptr <= ptr_next;
    end

    // storage array, cleared by reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)                        mem[i] <= '0;
            else if (wr_en && ptr == PW'(i))   mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[ptr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Protocol engine: address match, byte transfer, acknowledge, clock stretch.
// Assumes the controller changes SDA only while SCL is low, except for start and stop.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR7          = 7'h42,
    parameter logic [9:0] ADDR10         = 10'h2A5,
    parameter int         STRETCH_CYCLES = 12,
    parameter int         PW             = 4,
    localparam int        SW = (STRETCH_CYCLES < 1) ? 1 : $clog2(STRETCH_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ptr_load,
    output logic [PW-1:0]     ptr_val,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ptr_step,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              idle
);
    tgt_state_e        state, nxt;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh, txs;
    logic              ten_sel, ptr_first, ack_seen;
    logic [SW-1:0]     stretch;

    // main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            txs       <= '0;
            sda_pull  <= 1'b0;
            ten_sel   <= 1'b0;
            ptr_first <= 1'b0;
            ack_seen  <= 1'b0;
            stretch   <= '0;
            ptr_load  <= 1'b0;
            wr_en     <= 1'b0;
            ptr_step  <= 1'b0;
        end else begin
            ptr_load <= 1'b0;
            wr_en    <= 1'b0;
            ptr_step <= 1'b0;
            if (stretch != '0) stretch <= stretch - 1'b1;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                ten_sel  <= 1'b0;
                stretch  <= '0;
            end else if (start_det) begin
                state    <= ST_ADDR1;
                cnt      <= '0;
                sda_pull <= 1'b0;
                stretch  <= '0;
            end else begin
                case (state)
                    ST_ADDR1, ST_ADDR2, ST_WR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (state == ST_ADDR1) begin
                                if (sh[7:1] == ADDR7) begin
                                    state     <= ST_ACK;
                                    sda_pull  <= 1'b1;
                                    nxt       <= sh[0] ? ST_RD : ST_WR;
                                    ptr_first <= ~sh[0];
                                    ten_sel   <= 1'b0;
                                end else if (sh[7:3] == TEN_BIT_TAG && sh[2:1] == ADDR10[9:8]) begin
                                    if (!sh[0]) begin
                                        state    <= ST_ACK;
                                        sda_pull <= 1'b1;
                                        nxt      <= ST_ADDR2;
                                        ten_sel  <= 1'b0;
                                    end else if (ten_sel) begin
                                        state    <= ST_ACK;
                                        sda_pull <= 1'b1;
                                        nxt      <= ST_RD;
                                    end else begin
                                        state <= ST_WAIT;
                                    end
                                end else begin
                                    state   <= ST_WAIT;
                                    ten_sel <= 1'b0;
                                end
                            end else if (state == ST_ADDR2) begin
                                if (sh == ADDR10[7:0]) begin
                                    state     <= ST_ACK;
                                    sda_pull  <= 1'b1;
                                    nxt       <= ST_WR;
                                    ptr_first <= 1'b1;
                                    ten_sel   <= 1'b1;
                                end else begin
                                    state   <= ST_WAIT;
                                    ten_sel <= 1'b0;
                                end
                            end else begin
                                state    <= ST_ACK;
                                sda_pull <= 1'b1;
                                nxt      <= ST_WR;
                                if (ptr_first) begin
                                    ptr_load  <= 1'b1;
                                    ptr_first <= 1'b0;
                                end else begin
                                    wr_en <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state    <= nxt;
                            cnt      <= '0;
                            txs      <= rd_data;
                            sda_pull <= (nxt == ST_RD) ? ~rd_data[7] : 1'b0;
                            stretch  <= SW'(STRETCH_CYCLES);
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                state    <= ST_RACK;
                                sda_pull <= 1'b0;
                                ptr_step <= 1'b1;
                            end else begin
                                txs      <= txs << 1;
                                sda_pull <= ~txs[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            ack_seen <= ~sda_s;
                        end else if (scl_fall) begin
                            if (ack_seen) begin
                                state    <= ST_RD;
                                cnt      <= '0;
                                txs      <= rd_data;
                                sda_pull <= ~rd_data[7];
                                stretch  <= SW'(STRETCH_CYCLES);
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // register bank side and line drive outputs
    always_comb begin
        ptr_val  = sh[PW-1:0];
        wr_data  = sh;
        scl_pull = (stretch != '0);
        idle     = (state == ST_IDLE);
    end
endmodule

// File: rtl/i2c_ptr_target.sv
// Top of the serial register target: line synchronizer, protocol engine, register bank.
// Assumes the pull outputs drive open-drain pads; the inputs read the wired-AND level.
module i2c_ptr_target #(
    parameter logic [6:0] ADDR7          = 7'h42,
    parameter logic [9:0] ADDR10         = 10'h2A5,
    parameter int         REG_DEPTH      = 16,
    parameter int         STRETCH_CYCLES = 12,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic sda_pull_o
);
    localparam int PW = $clog2(REG_DEPTH);
    localparam int DW = i2c_tgt_pkg::BYTE_W;

    logic          scl_sync, sda_sync, scl_rise, scl_fall, start_seen, stop_seen;
    logic          ptr_load, wr_en, ptr_step, fsm_idle;
    logic [PW-1:0] ptr_val;
    logic [DW-1:0] wr_data, rd_data;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_seen), .stop_det(stop_seen)
    );

    i2c_tgt_fsm #(
        .ADDR7(ADDR7), .ADDR10(ADDR10), .STRETCH_CYCLES(STRETCH_CYCLES), .PW(PW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_sync), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_seen), .stop_det(stop_seen), .rd_data(rd_data),
        .ptr_load(ptr_load), .ptr_val(ptr_val), .wr_en(wr_en), .wr_data(wr_data),
        .ptr_step(ptr_step), .sda_pull(sda_pull_o), .scl_pull(scl_pull_o), .idle(fsm_idle)
    );

    i2c_reg_bank #(.DEPTH(REG_DEPTH), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val),
        .wr_en(wr_en), .wr_data(wr_data), .ptr_step(ptr_step), .rd_data(rd_data)
    );
endmodule

// File: rtl/i2c_ptr_target_chk.sv
// Property checker for the serial register target, bound to the top.
// Assumes synchronous active-low reset; all properties are off during reset.
module i2c_ptr_target_chk #(
    parameter int STRETCH_CYCLES = 12
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_det,
    input logic idle,
    input logic sda_pull,
    input logic scl_pull
);
    logic [15:0] run;

    // length of the current SCL hold
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= '0;
        else if (scl_pull) run <= run + 1'b1;
        else               run <= '0;
    end

    a_r11_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_pull && !scl_pull));

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!sda_pull && !scl_pull));

    a_r2_sda_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !$past(scl_s));

    a_r9_stretch_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> !$past(scl_s));

    a_r9_stretch_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run <= 16'(STRETCH_CYCLES));
endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .stop_det(stop_seen),
    .idle(fsm_idle), .sda_pull(sda_pull_o), .scl_pull(scl_pull_o)
);

// File: tb/i2c_ptr_target_tb_top.sv
// Bench: controller model on open-drain lines, vector loop, directed corner tests.
module i2c_ptr_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int QTR        = 3;
    localparam int STRETCH    = 12;
    localparam int WATCHDOG   = 150000;
    localparam logic [7:0] W7  = 8'h84, R7 = 8'h85;
    localparam logic [7:0] H10W = 8'hF4, H10R = 8'hF5, L10 = 8'hA5;

    // {pointer, write data, expected readback}
    localparam logic [19:0] VEC [6] = '{
        {4'd0,  8'h11, 8'h11}, {4'd15, 8'hF0, 8'hF0}, {4'd7, 8'hA5, 8'hA5},
        {4'd3,  8'h3C, 8'h3C}, {4'd2,  8'h77, 8'h77}, {4'd15, 8'h5E, 8'h5E}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic tb_scl_pull = 1'b0, tb_sda_pull = 1'b0;
    logic scl_pull_o, sda_pull_o;
    wire  scl_line = ~(tb_scl_pull | scl_pull_o);
    wire  sda_line = ~(tb_sda_pull | sda_pull_o);
    int   checks = 0, errors = 0, run = 0, pulses = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ptr_target #(.STRETCH_CYCLES(STRETCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        tb_scl_pull = 1'b0;
        do @(negedge clk); while (!scl_line);
    endtask

    task automatic bus_start();
        wc(HALF); tb_sda_pull = 1'b1; wc(HALF); tb_scl_pull = 1'b1;
    endtask

    task automatic bus_rstart();
        wc(QTR); tb_sda_pull = 1'b0; wc(HALF-QTR); scl_up(); wc(HALF);
        tb_sda_pull = 1'b1; wc(HALF); tb_scl_pull = 1'b1;
    endtask

    task automatic bus_stop();
        wc(QTR); tb_sda_pull = 1'b1; wc(HALF-QTR); scl_up(); wc(HALF);
        tb_sda_pull = 1'b0; wc(HALF);
    endtask

    task automatic send_bit(input bit b);
        wc(QTR); tb_sda_pull = ~b; wc(HALF-QTR); scl_up(); wc(HALF); tb_scl_pull = 1'b1;
    endtask

    task automatic recv_bit(output bit b);
        wc(QTR); tb_sda_pull = 1'b0; wc(HALF-QTR); scl_up(); wc(HALF/2);
        b = sda_line; wc(HALF/2); tb_scl_pull = 1'b1;
    endtask

    task automatic wr_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input bit ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~ack);
    endtask

    task automatic reg_write(input logic [3:0] p, input logic [7:0] d);
        bit a;
        bus_start();
        wr_byte(W7, a);      chk("R2 own 7-bit address ack", a, 1);
        wr_byte({4'h0, p}, a); chk("R5 pointer byte ack", a, 1);
        wr_byte(d, a);       chk("R5 data byte ack", a, 1);
        bus_stop();
    endtask

    task automatic reg_read(input logic [3:0] p, output logic [7:0] d);
        bit a;
        bus_start();
        wr_byte(W7, a); wr_byte({4'h0, p}, a);
        bus_rstart();
        wr_byte(R7, a); chk("R10 read header after repeated start ack", a, 1);
        rd_byte(1'b0, d);
        bus_stop();
    endtask

    // stretch length monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (scl_pull_o) run++;
            else if (run != 0) begin
                pulses++;
                chk("R9 stretch length", run, STRETCH);
                run = 0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit a;
        wc(4); rst_n = 1'b1; wc(4);
        chk("R1 sda pull after reset", sda_pull_o, 0);
        chk("R1 scl pull after reset", scl_pull_o, 0);
        reg_read(4'd9, d); chk("R1 register cleared by reset", d, 8'h00);

        // vector loop: write then read back (R5, R6)
        for (int i = 0; i < 6; i++) begin
            reg_write(VEC[i][19:16], VEC[i][15:8]);
            reg_read(VEC[i][19:16], d);
            chk("R6 readback of vector", d, VEC[i][7:0]);
        end

        // R7: burst write across the top, burst read back
        bus_start();
        wr_byte(W7, a); wr_byte(8'h0E, a);
        wr_byte(8'h01, a); wr_byte(8'h02, a); wr_byte(8'h03, a); wr_byte(8'h04, a);
        chk("R5 last burst byte ack", a, 1);
        bus_stop();
        bus_start();
        wr_byte(W7, a); wr_byte(8'h0E, a); bus_rstart(); wr_byte(R7, a);
        rd_byte(1'b1, d); chk("R6 burst read byte 14", d, 8'h01);
        rd_byte(1'b1, d); chk("R6 burst read byte 15", d, 8'h02);
        rd_byte(1'b1, d); chk("R7 wrap read byte 0", d, 8'h03);
        rd_byte(1'b0, d); chk("R7 wrap read byte 1", d, 8'h04);
        bus_stop();
        chk("R11 sda released after stop", sda_pull_o, 0);
        chk("R11 scl released after stop", scl_pull_o, 0);
        // pointer is now 2 and persists across transfers
        bus_start(); wr_byte(R7, a); rd_byte(1'b0, d); bus_stop();
        chk("R6 read without pointer uses advanced pointer", d, 8'h77);

        // R2: foreign address ignored
        bus_start();
        wr_byte(8'h50, a); chk("R2 foreign address not acked", a, 0);
        wr_byte(8'h02, a); wr_byte(8'hEE, a);
        bus_stop();
        reg_read(4'd2, d); chk("R2 foreign write has no effect", d, 8'h77);

        // R3: 10-bit write, R4: 10-bit read
        bus_start();
        wr_byte(H10W, a); chk("R3 10-bit header ack", a, 1);
        wr_byte(L10, a);  chk("R3 10-bit low byte ack", a, 1);
        wr_byte(8'h04, a); wr_byte(8'h5A, a);
        bus_stop();
        bus_start();
        wr_byte(H10W, a); wr_byte(L10, a); wr_byte(8'h04, a);
        bus_rstart();
        wr_byte(H10R, a); chk("R4 10-bit read header ack", a, 1);
        rd_byte(1'b0, d); chk("R4 10-bit read data", d, 8'h5A);
        bus_stop();
        bus_start();
        wr_byte(H10W, a); wr_byte(8'h33, a); chk("R3 wrong low byte not acked", a, 0);
        bus_stop();
        bus_start();
        wr_byte(H10R, a); chk("R4 read header without prior match not acked", a, 0);
        bus_stop();

        // R8: NAK from controller releases SDA
        bus_start();
        wr_byte(W7, a); wr_byte(8'h07, a); bus_rstart(); wr_byte(R7, a);
        rd_byte(1'b0, d); chk("R8 byte before NAK", d, 8'hA5);
        rd_byte(1'b0, d); chk("R8 clocks after NAK read all ones", d, 8'hFF);
        bus_stop();

        chk("R9 stretch pulses observed", (pulses > 20), 1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule